// File: doc/BRIEF.md
# Change-of-State Digital Input Port

This block is a 48-line digital input peripheral on a byte-wide I/O bus with an 8-byte address window. It synchronises 48 external inputs to the core clock and presents them to the host as six 8-bit groups. Each group can be enabled for change-of-state detection. A change in either direction on any line of an enabled group latches a status bit for that group and raises an interrupt.

The host enables groups by writing a 6-bit mask to offset 7. When the interrupt arrives, the host reads offset 7. That read returns the latched groups and an active-low pending flag, and it clears the latch. The host then reads the data offsets of the flagged groups and works out which lines changed. Masking individual lines is left to host software.

Top module: `cos_input_port`

## Requirements
- R1: The synchronised inputs read as bytes at offsets 0, 1, 2, 4, 5 and 6, one offset per group in that order (group 0 at offset 0, group 3 at offset 4, group 5 at offset 6). Input n appears at bit (n mod 8) of its group's byte.
- R2: A read of offset 3 returns 8'h00.
- R3: Each input passes through a two-flop synchroniser. A change on a pin shows up in the data byte after the second rising clock edge following the change, and not after the first.
- R4: After reset the enable mask is zero, no status bit is latched, irq is low, and a read of offset 7 returns 8'h40.
- R5: A write to offset 7 loads bus_wdata[5:0] into the enable mask, where bit k enables group k. The write does not change the latched status.
- R6: When group k is enabled, a rising or a falling change on any of its lines sets status bit k on the third rising edge after the pin change. Changes in several groups in the same cycle set all of their bits.
- R7: Changes in a group whose enable bit is 0 set no status bit and do not raise irq.
- R8: A read of offset 7 returns the status bits in bits 0 to 5, the inverse of the pending state in bit 6 (0 means an interrupt is pending), and 0 in bit 7.
- R9: A read strobe at offset 7 clears all latched status bits at that clock edge. An enabled change detected in the same cycle as the strobe stays latched.
- R10: irq is an active-high level. It is high exactly when at least one status bit is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| pin_in | input | 48 | External digital inputs, asynchronous to clk |
| bus_addr | input | 3 | Byte offset within the window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; a strobe at offset 7 clears the status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational from registered state |
| irq | output | 1 | Active-high interrupt request level |

## Verification
The inputs are first driven with a distinct byte in every group. This separates a correct offset map from a map shifted across the hole at offset 3 or a map with two bytes swapped. Single-line rising and falling changes in enabled groups separate either-edge detection from single-edge detection. A change in a disabled group shows whether the enable mask gates the latch. Two groups changing together show whether the group bits are kept apart. A change timed to arrive on the same edge as a status-clearing read shows whether an event is lost in the clear. The third rising edge after a pin change is sampled on its own, which separates the correct synchroniser depth from a shallower or deeper pipeline.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam int GRP_W     = 8;
  localparam int N_GRP     = 6;
  localparam int N_IN      = GRP_W * N_GRP;
  localparam int ADDR_W    = 3;
  localparam int DATA_W    = 8;
  localparam int SYNC_DEPTH = 2;
  localparam int PEND_BIT  = 6;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 3'd7;
  localparam logic [ADDR_W-1:0] HOLE_ADDR = 3'd3;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_STAT = 2'd1,
    SEL_NONE = 2'd2
  } rd_sel_e;

  function automatic rd_sel_e sel_of_addr(logic [ADDR_W-1:0] a);
    if (a == STAT_ADDR)      return SEL_STAT;
    else if (a == HOLE_ADDR) return SEL_NONE;
    else                     return SEL_DATA;
  endfunction

  function automatic logic [ADDR_W-1:0] grp_of_addr(logic [ADDR_W-1:0] a);
    if (a < HOLE_ADDR) return a;
    else               return a - 3'd1;
  endfunction
endpackage

// File: rtl/cos_rst_sync.sv
module cos_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int W     = 48,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q_sync,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] stage_q [DEPTH];
  logic [W-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < DEPTH; s++) begin : g_stage
      logic [W-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = d;
      end else begin : g_rest
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stage_q[DEPTH-1];
  end

  assign q_sync = stage_q[DEPTH-1];
  assign q_prev = prev_q;

  // R3: the previous-value register follows the synchronised value by one cycle
  a_r3_prev_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (q_prev == $past(q_sync)));
endmodule

// File: rtl/cos_detect.sv
module cos_detect
  import cos_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  cur,
  input  logic [N_IN-1:0]  prev,
  input  logic             en_wr,
  input  logic [N_GRP-1:0] en_wdata,
  input  logic             clr,
  output logic [N_GRP-1:0] status,
  output logic [N_GRP-1:0] enable,
  output logic             irq
);
  logic [N_GRP-1:0] grp_edge;
  logic [N_GRP-1:0] hit;
  logic [N_GRP-1:0] stat_q, stat_d;
  logic [N_GRP-1:0] en_q, en_d;
  logic             irq_q, irq_d;

  genvar g;
  generate
    for (g = 0; g < N_GRP; g++) begin : g_grp
      assign grp_edge[g] = |(cur[g*GRP_W +: GRP_W] ^ prev[g*GRP_W +: GRP_W]);

      // R7: a status bit rises only for a group that was enabled
      a_r7_disabled_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[g]) |-> $past(en_q[g]));
      // R9: an enabled change is latched even when a clear happens
      a_r9_edge_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_edge[g] && en_q[g]) |=> stat_q[g]);
    end
  endgenerate

  always_comb begin
    hit    = grp_edge & en_q;
    stat_d = (clr ? '0 : stat_q) | hit;
    en_d   = en_wr ? en_wdata : en_q;
    irq_d  = |stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= irq_d;
      if (en_wr) en_q <= en_d;
    end
  end

  assign status = stat_q;
  assign enable = en_q;
  assign irq    = irq_q;

  // R9: a clear with no simultaneous enabled change empties the latch
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (hit == '0)) |=> (stat_q == '0));
  // R5: the mask only moves on a write
  a_r5_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(en_q));
endmodule

// File: rtl/cos_regs.sv
module cos_regs
  import cos_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_IN-1:0]   data_in,
  input  logic [N_GRP-1:0]  status,
  input  logic              pending,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] grp_bytes [N_GRP];
  logic [DATA_W-1:0] stat_byte;
  rd_sel_e           sel;
  logic [ADDR_W-1:0] grp_idx;

  genvar g;
  generate
    for (g = 0; g < N_GRP; g++) begin : g_byte
      assign grp_bytes[g] = data_in[g*GRP_W +: GRP_W];
    end
  endgenerate

  always_comb begin
    stat_byte           = '0;
    stat_byte[N_GRP-1:0] = status;
    stat_byte[PEND_BIT] = ~pending;
    sel     = sel_of_addr(addr);
    grp_idx = grp_of_addr(addr);
    case (sel)
      SEL_DATA: rdata = grp_bytes[grp_idx];
      SEL_STAT: rdata = stat_byte;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/cos_input_port.sv
module cos_input_port
  import cos_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   pin_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic             core_rst_n;
  logic [N_IN-1:0]  in_sync;
  logic [N_IN-1:0]  in_prev;
  logic [N_GRP-1:0] status;
  logic [N_GRP-1:0] enable;
  logic             wr_stat;
  logic             rd_stat;

  assign wr_stat = bus_wr && (bus_addr == STAT_ADDR);
  assign rd_stat = bus_rd && (bus_addr == STAT_ADDR);

  cos_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (core_rst_n)
  );

  cos_sync #(.W(N_IN), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .d      (pin_in),
    .q_sync (in_sync),
    .q_prev (in_prev)
  );

  cos_detect u_det (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .cur      (in_sync),
    .prev     (in_prev),
    .en_wr    (wr_stat),
    .en_wdata (bus_wdata[N_GRP-1:0]),
    .clr      (rd_stat),
    .status   (status),
    .enable   (enable),
    .irq      (irq)
  );

  cos_regs u_regs (
    .addr    (bus_addr),
    .data_in (in_sync),
    .status  (status),
    .pending (irq),
    .rdata   (bus_rdata)
  );

  // R8: the pending flag in the status byte is the inverse of the request line
  a_r8_pending_flag: assert property (@(posedge clk) disable iff (!core_rst_n)
    (bus_addr == STAT_ADDR) |-> (bus_rdata[PEND_BIT] == !irq && bus_rdata[7] == 1'b0));
  // R2: the unused offset reads as zero
  a_r2_hole_zero: assert property (@(posedge clk) disable iff (!core_rst_n)
    (bus_addr == HOLE_ADDR) |-> (bus_rdata == '0));
  // R10: the request line is high only while some group is latched
  a_r10_irq_level: assert property (@(posedge clk) disable iff (!core_rst_n)
    irq |-> (status != '0));
endmodule

// File: tb/cos_input_port_bench.sv
`timescale 1ns/100ps
module cos_input_port_bench;
  logic        clk;
  logic        rst_n;
  logic [47:0] pins;
  logic [2:0]  addr;
  logic        wr, rd;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit cmp_en   = 0;
  bit done     = 0;

  cos_input_port u_cos_input_port (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .bus_addr(addr),
    .bus_wr(wr), .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  // behavioural reference: history of sampled pins, enable and latched groups
  logic [47:0] hist[$];
  logic [5:0]  m_en, m_stat;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{48'd0, 48'd0, 48'd0};
      m_en = 0; m_stat = 0;
    end else begin
      logic [47:0] ch;
      logic [5:0]  hv;
      ch = hist[1] ^ hist[2];
      for (int k = 0; k < 6; k++) hv[k] = (ch[k*8 +: 8] != 0) && m_en[k];
      if (rd && addr == 3'd7) m_stat = hv;
      else                    m_stat = m_stat | hv;
      if (wr && addr == 3'd7) m_en = wdata[5:0];
      hist.push_front(pins);
      void'(hist.pop_back());
    end
  end

  function automatic logic [7:0] model_rd(logic [2:0] a);
    if (a == 3'd7) return {1'b0, ~|m_stat, m_stat};
    if (a == 3'd3) return 8'h00;
    if (a < 3'd3)  return hist[1][a*8 +: 8];
    return hist[1][(a-1)*8 +: 8];
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (cmp_en) begin
      if (addr == 3'd7)      check("R8 model status byte", rdata, model_rd(addr));
      else if (addr == 3'd3) check("R2 model hole", rdata, model_rd(addr));
      else                   check("R1 model data byte", rdata, model_rd(addr));
      check("R10 model irq", {7'd0, irq}, {7'd0, |m_stat});
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic look(logic [2:0] a);
    addr = a; #1;
  endtask

  task automatic rd_clear();
    addr = 3'd7; rd = 1; tick(); rd = 0; #1;
  endtask

  initial begin
    rst_n = 0; pins = 0; addr = 0; wr = 0; rd = 0; wdata = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    tick(4);
    cmp_en = 1;

    // R4 reset state
    look(3'd7);
    check("R4 status after reset", rdata, 8'h40);
    check("R4 irq after reset", {7'd0, irq}, 8'h00);

    // R1 offset map, all groups disabled
    pins = {8'hA5, 8'h3C, 8'h0F, 8'h81, 8'h7E, 8'h11};
    tick(3);
    look(3'd0); check("R1 offset 0", rdata, 8'h11);
    look(3'd1); check("R1 offset 1", rdata, 8'h7E);
    look(3'd2); check("R1 offset 2", rdata, 8'h81);
    look(3'd4); check("R1 offset 4", rdata, 8'h0F);
    look(3'd5); check("R1 offset 5", rdata, 8'h3C);
    look(3'd6); check("R1 offset 6", rdata, 8'hA5);
    look(3'd3); check("R2 offset 3 zero", rdata, 8'h00);

    // R3 synchroniser depth
    look(3'd1);
    pins[8] = 1'b1;
    tick(); check("R3 after one edge", rdata, 8'h7E);
    tick(); check("R3 after two edges", rdata, 8'h7F);

    // R7 disabled group ignored
    pins[16] = 1'b0;
    tick(4);
    look(3'd7);
    check("R7 disabled status", rdata, 8'h40);
    check("R7 disabled irq", {7'd0, irq}, 8'h00);

    // R5 enable write leaves status alone
    wdata = 8'h07; wr = 1; tick(); wr = 0; #1;
    check("R5 write keeps status", rdata, 8'h40);

    // R6 rising edge in group 2
    pins[17] = 1'b1;
    tick(2); check("R6 not yet after two edges", {7'd0, irq}, 8'h00);
    tick();  check("R6 irq on third edge", {7'd0, irq}, 8'h01);
    check("R8 status byte rising", rdata, 8'h04);

    // R9 clear
    rd_clear();
    check("R9 cleared status", rdata, 8'h40);
    check("R10 irq drops", {7'd0, irq}, 8'h00);

    // R6 falling edge in group 2
    pins[17] = 1'b0;
    tick(3); check("R6 falling edge", rdata, 8'h04);
    rd_clear();

    // R6 two groups together
    pins[3] = ~pins[3]; pins[12] = ~pins[12];
    tick(3); check("R6 two groups", rdata, 8'h03);
    rd_clear();

    // R9 edge on the clearing edge is kept
    pins[9] = ~pins[9];
    tick(3); check("R9 group1 latched", rdata, 8'h02);
    pins[0] = ~pins[0];
    tick(2);
    rd = 1; tick(); rd = 0; #1;
    check("R9 simultaneous edge kept", rdata, 8'h01);
    check("R10 irq stays", {7'd0, irq}, 8'h01);

    // R7 disabled group 5 while latched
    pins[47] = ~pins[47];
    tick(4); check("R7 group5 ignored", rdata, 8'h01);
    rd_clear();
    check("R10 irq low after clear", {7'd0, irq}, 8'h00);

    // R5 new mask enables group 5 only
    wdata = 8'h20; wr = 1; tick(); wr = 0;
    pins[1] = ~pins[1]; pins[40] = ~pins[40];
    tick(3); look(3'd7); check("R5 new mask", rdata, 8'h20);
    rd_clear();
    tick(2);

    cmp_en = 0;
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule